// File: doc/BRIEF.md
# Paged Memory Access Checker

This block sits beside a processor's address path and judges every virtual access against the descriptor of the page it falls in. A 16-bit virtual address is split so that its three top bits pick one of eight pages. Together with the two-bit processor mode, those bits select one of 32 descriptors. The access kind (read or write), the page's access-control code and its length limit decide whether the access is let through, aborted, or let through with a trap request.

The first abort records its cause flags, the mode and the page number in the control/status register. It then freezes that status, and the captured fetch address, until software writes the control/status register again. A second register holds the virtual address of the most recent instruction fetch, so after an aborted fetch it names the failing location. Address translation itself is not part of this block. The per-page address registers are kept only as readable and writable storage beside the descriptors.

Top module: `pageAccessChecker`

## Requirements
- R1: After reset, the control/status register, the fetch-address register and all descriptors and address registers read 0, and neither request output is high.
- R2: The register port decodes `regAddr[6:5]`: 00 selects descriptor `regAddr[4:0]`, and 01 selects address register `regAddr[4:0]`, where the index is mode*8+page. A descriptor keeps only the length field (bits 14:8), the expand-down bit (bit 3) and the access code (bits 2:0), and its other bits read 0. An address register keeps all 16 bits.
- R3: With `regAddr[6:5]`=10, address bit 0 equal to 0 selects the control/status register. Its writable bits are 15 (not-resident), 14 (length), 13 (read-only), 9 (trap enable), 6:5 (mode), 3:1 (page) and 0 (enable). All other bits, including 11 and 10, read 0.
- R4: With the enable bit clear, no access raises a request or changes the status.
- R5: Access codes 0, 3 and 7 mean not resident. Any access to such a page aborts and sets only bit 15.
- R6: Access codes 1 and 2 are read-only. A write aborts and sets bit 13, and a read passes.
- R7: With expand-down clear, an access whose block number (address bits 12:6) is greater than the length field aborts and sets bit 14.
- R8: With expand-down set, an access whose block number is less than the length field aborts and sets bit 14.
- R9: Any access in mode 2 (binary 10) aborts and sets bits 15 and 14, whatever the descriptor says.
- R10: The abort request is a one-cycle pulse in the cycle after the access. The same clock edge writes the access mode into bits 6:5 and the page into bits 3:1.
- R11: While any of bits 15:13 is set, later aborts still pulse the abort output but change neither the status nor the fetch-address register. A write to the control/status register releases the freeze.
- R12: The fetch-address register (`regAddr[6:5]`=10, bit 0 equal to 1, read-only) loads the address of each enabled fetch access, including one that aborts, unless the status is frozen.
- R13: When trap enable is set and no abort happens, a trap pulse follows: a read of an access-code 1 page, any access to an access-code 4 page, or a write to an access-code 5 page. Code 6 never traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| accValid | input | 1 | An access is presented this cycle |
| vaddr | input | 16 | Virtual address of the access |
| accWrite | input | 1 | 1 for a write, 0 for a read |
| accMode | input | 2 | Processor mode of the access |
| accFetch | input | 1 | The access is an instruction fetch |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 7 | Register select |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| abortReq | output | 1 | Abort request, one cycle after the access |
| trapReq | output | 1 | Trap request, one cycle after the access |

## Verification
Some properties are checked on every cycle. Mode 2 always aborts. A disabled checker stays silent. No trap is raised while trap enable is clear. A frozen status and fetch address stay put until software writes the control/status register. A fresh abort always leaves a flag behind. Other behaviour is shown only by the bench's scenarios. These are the exact status words recorded for each abort cause, the boundary blocks of both expansion directions, which access codes trap for reads and for writes, the masking of unimplemented bits on readback, and the fetch-address register following a non-aborting fetch.

// File: rtl/mmuCheckPkg.sv
package mmuCheckPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic       descWr;
    logic       parWr;
    logic       ctlWr;
    logic       capture;
    logic       pcLoad;
    logic [2:0] flags;   // {notResident, length, readOnly}
  } mmuStrobeT;

  localparam int PLF_W = 7;
  localparam int ACF_W = 3;
  localparam logic [1:0] MODE_BAD = 2'b10;
endpackage

// File: rtl/mmuPageFile.sv
module mmuPageFile #(
  parameter int IDX_W = 5,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             descWr,
  input  logic             parWr,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [DW-1:0]    wrData,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [IDX_W-1:0] chkIdx,
  output logic [DW-1:0]    rdDesc,
  output logic [DW-1:0]    rdPar,
  output logic [DW-1:0]    chkDesc
);
  localparam int ENTRIES = 2 ** IDX_W;
  // only length, expand-down and access-code bits are stored
  localparam logic [DW-1:0] DESC_MASK = 16'h7F0F;

  logic [DW-1:0] descMem [ENTRIES];
  logic [DW-1:0] parMem  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        descMem[e] <= '0;
        parMem[e]  <= '0;
      end else begin
        if (descWr && wrIdx == IDX_W'(e)) descMem[e] <= wrData & DESC_MASK;
        if (parWr && wrIdx == IDX_W'(e))  parMem[e]  <= wrData;
      end
    end
  end

  assign rdDesc  = descMem[rdIdx];
  assign rdPar   = parMem[rdIdx];
  assign chkDesc = descMem[chkIdx];
endmodule

// File: rtl/mmuDatapath.sv
module mmuDatapath
  import mmuCheckPkg::*;
#(
  parameter int VA_W = 16,
  parameter int PAGE_W = 3,
  parameter int MODE_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mmuStrobeT               strb,
  input  logic [VA_W-1:0]         vaddr,
  input  logic [MODE_W-1:0]       accMode,
  input  logic [PAGE_W+MODE_W+1:0] regAddr,
  input  logic [15:0]             regWrData,
  output logic [15:0]             regRdData,
  output logic [15:0]             chkDesc,
  output logic                    mmuEnable,
  output logic                    trapEnable
);
  localparam int IDX_W = PAGE_W + MODE_W;

  logic [2:0]        flagsQ;
  logic              trapEnQ;
  logic [MODE_W-1:0] modeQ;
  logic [PAGE_W-1:0] pageQ;
  logic              enQ;
  logic [VA_W-1:0]   fetchAddrQ;
  logic              frozen;
  logic [15:0]       rdDesc, rdPar, ctlWord;
  logic [IDX_W-1:0]  chkIdx;

  assign frozen     = |flagsQ;
  assign mmuEnable  = enQ;
  assign trapEnable = trapEnQ;
  assign chkIdx     = {accMode, vaddr[VA_W-1 -: PAGE_W]};

  mmuPageFile #(.IDX_W(IDX_W), .DW(16)) u_pages (
    .clk     (clk),
    .rstN    (rstN),
    .descWr  (strb.descWr),
    .parWr   (strb.parWr),
    .wrIdx   (regAddr[IDX_W-1:0]),
    .wrData  (regWrData),
    .rdIdx   (regAddr[IDX_W-1:0]),
    .chkIdx  (chkIdx),
    .rdDesc  (rdDesc),
    .rdPar   (rdPar),
    .chkDesc (chkDesc)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ  <= '0;
      trapEnQ <= 1'b0;
      modeQ   <= '0;
      pageQ   <= '0;
      enQ     <= 1'b0;
    end else if (strb.ctlWr) begin
      flagsQ  <= regWrData[15:13];
      trapEnQ <= regWrData[9];
      modeQ   <= regWrData[6:5];
      pageQ   <= regWrData[3:1];
      enQ     <= regWrData[0];
    end else if (strb.capture && !frozen) begin
      flagsQ <= strb.flags;
      modeQ  <= accMode;
      pageQ  <= vaddr[VA_W-1 -: PAGE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fetchAddrQ <= '0;
    else if (strb.pcLoad && !frozen) fetchAddrQ <= vaddr;
  end

  assign ctlWord = {flagsQ, 3'b000, trapEnQ, 2'b00, modeQ, 1'b0, pageQ, enQ};

  always_comb begin
    unique case (regAddr[IDX_W+1:IDX_W])
      2'b00:   regRdData = rdDesc;
      2'b01:   regRdData = rdPar;
      2'b10:   regRdData = regAddr[0] ? fetchAddrQ : ctlWord;
      default: regRdData = '0;
    endcase
  end

  // R11: frozen status and fetch address hold until a status write
  p_freeze_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    frozen && !strb.ctlWr |=> $stable(flagsQ) && $stable(modeQ) && $stable(pageQ) && $stable(fetchAddrQ));

  // R10: a fresh abort always leaves a cause flag behind
  p_capture_flags_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && !frozen && !strb.ctlWr |=> flagsQ != 3'b000);
endmodule

// File: rtl/mmuControl.sv
module mmuControl
  import mmuCheckPkg::*;
#(
  parameter int VA_W = 16,
  parameter int PAGE_W = 3,
  parameter int MODE_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     accValid,
  input  logic [VA_W-1:0]          vaddr,
  input  logic                     accWrite,
  input  logic [MODE_W-1:0]        accMode,
  input  logic                     accFetch,
  input  logic                     regWrEn,
  input  logic [PAGE_W+MODE_W+1:0] regAddr,
  input  logic [15:0]              chkDesc,
  input  logic                     mmuEnable,
  input  logic                     trapEnable,
  output mmuStrobeT                strb,
  output logic                     abortReq,
  output logic                     trapReq
);
  localparam int IDX_W = PAGE_W + MODE_W;
  localparam int OFF_W = VA_W - PAGE_W;

  logic [ACF_W-1:0] acf;
  logic [PLF_W-1:0] plf, blk;
  logic             expDown, checkOn, badMode, notRes, lenErr, roErr, trapCond;
  logic             abortNow, trapNow;
  logic [2:0]       flagsNow;

  assign acf     = chkDesc[ACF_W-1:0];
  assign expDown = chkDesc[3];
  assign plf     = chkDesc[8 +: PLF_W];
  assign blk     = vaddr[OFF_W-1 -: PLF_W];

  assign checkOn  = accValid && mmuEnable;
  assign badMode  = (accMode == MODE_BAD);
  assign notRes   = (acf == 3'd0) || (acf == 3'd3) || (acf == 3'd7);
  assign lenErr   = expDown ? (blk < plf) : (blk > plf);
  assign roErr    = accWrite && ((acf == 3'd1) || (acf == 3'd2));
  assign trapCond = ((acf == 3'd1) && !accWrite) || (acf == 3'd4) ||
                    ((acf == 3'd5) && accWrite);

  always_comb begin
    if (badMode)     flagsNow = 3'b110;
    else if (notRes) flagsNow = 3'b100;
    else             flagsNow = {1'b0, lenErr, roErr};
  end

  assign abortNow = checkOn && (flagsNow != 3'b000);
  assign trapNow  = checkOn && !abortNow && trapEnable && trapCond;

  always_comb begin
    strb.descWr  = regWrEn && (regAddr[IDX_W+1:IDX_W] == 2'b00);
    strb.parWr   = regWrEn && (regAddr[IDX_W+1:IDX_W] == 2'b01);
    strb.ctlWr   = regWrEn && (regAddr[IDX_W+1:IDX_W] == 2'b10) && !regAddr[0];
    strb.capture = abortNow;
    strb.pcLoad  = checkOn && accFetch;
    strb.flags   = flagsNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abortReq <= 1'b0;
      trapReq  <= 1'b0;
    end else begin
      abortReq <= abortNow;
      trapReq  <= trapNow;
    end
  end

  // R9: mode 2 always aborts
  p_bad_mode_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    accValid && mmuEnable && accMode == MODE_BAD |=> abortReq);

  // R4: a disabled checker raises nothing
  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !mmuEnable |=> !abortReq && !trapReq);

  // R13: no trap without trap enable
  p_trap_gated_r13: assert property (@(posedge clk) disable iff (!rstN)
    !trapEnable |=> !trapReq);
endmodule

// File: rtl/pageAccessChecker.sv
module pageAccessChecker
  import mmuCheckPkg::*;
#(
  parameter int VA_W = 16,
  parameter int PAGE_W = 3,
  parameter int MODE_W = 2,
  localparam int RA_W = PAGE_W + MODE_W + 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic [VA_W-1:0] vaddr,
  input  logic            accWrite,
  input  logic [MODE_W-1:0] accMode,
  input  logic            accFetch,
  input  logic            regWrEn,
  input  logic [RA_W-1:0] regAddr,
  input  logic [15:0]     regWrData,
  output logic [15:0]     regRdData,
  output logic            abortReq,
  output logic            trapReq
);
  mmuStrobeT   strb;
  logic [15:0] chkDesc;
  logic        mmuEnable, trapEnable;

  mmuControl #(.VA_W(VA_W), .PAGE_W(PAGE_W), .MODE_W(MODE_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .vaddr      (vaddr),
    .accWrite   (accWrite),
    .accMode    (accMode),
    .accFetch   (accFetch),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .chkDesc    (chkDesc),
    .mmuEnable  (mmuEnable),
    .trapEnable (trapEnable),
    .strb       (strb),
    .abortReq   (abortReq),
    .trapReq    (trapReq)
  );

  mmuDatapath #(.VA_W(VA_W), .PAGE_W(PAGE_W), .MODE_W(MODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .vaddr      (vaddr),
    .accMode    (accMode),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .chkDesc    (chkDesc),
    .mmuEnable  (mmuEnable),
    .trapEnable (trapEnable)
  );
endmodule

// File: tb/pageAccessChecker_tb.sv
module pageAccessChecker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [15:0] vaddr = '0;
  logic        accWrite = 1'b0;
  logic [1:0]  accMode = '0;
  logic        accFetch = 1'b0;
  logic        regWrEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        abortReq, trapReq;

  localparam logic [6:0] A_DESC = 7'h00;
  localparam logic [6:0] A_PAR  = 7'h20;
  localparam logic [6:0] A_CTL  = 7'h40;
  localparam logic [6:0] A_FADR = 7'h41;

  always #2 clk = ~clk;  // 250 MHz

  pageAccessChecker u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .vaddr(vaddr),
    .accWrite(accWrite), .accMode(accMode), .accFetch(accFetch),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .abortReq(abortReq), .trapReq(trapReq)
  );

  typedef struct {
    logic  expAbort;
    logic  expTrap;
    int    due;
    string tag;
  } expItemT;

  expItemT scoreQ[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc++;

  // monitor: compares outputs against expected items
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (scoreQ.size() > 0 && scoreQ[0].due == cyc) begin
        expItemT it;
        it = scoreQ.pop_front();
        nChecks++;
        if (abortReq !== it.expAbort || trapReq !== it.expTrap) begin
          nFails++;
          $display("FAIL %s: abort/trap got %b%b expected %b%b",
                   it.tag, abortReq, trapReq, it.expAbort, it.expTrap);
        end
      end else if (abortReq !== 1'b0 || trapReq !== 1'b0) begin
        nChecks++;
        nFails++;
        $display("FAIL R10 stray pulse: abort/trap got %b%b expected 00", abortReq, trapReq);
      end
    end
  end

  task automatic access(input logic [15:0] a, input logic w, input logic [1:0] m,
                        input logic f, input logic ea, input logic et, input string tag);
    expItemT it;
    @(negedge clk);
    vaddr = a; accWrite = w; accMode = m; accFetch = f; accValid = 1'b1;
    it.expAbort = ea; it.expTrap = et; it.due = cyc + 1; it.tag = tag;
    scoreQ.push_back(it);
    @(negedge clk);
    accValid = 1'b0; accFetch = 1'b0; accWrite = 1'b0;
  endtask

  task automatic regWrite(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(input logic [6:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #2;
    nChecks++;
    if (regRdData !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, regRdData, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regCheck(A_CTL, 16'h0000, "R1 status after reset");
    regCheck(A_FADR, 16'h0000, "R1 fetch addr after reset");
    regCheck(A_DESC + 7'd9, 16'h0000, "R1 descriptor after reset");
    // R2 storage masks
    regWrite(A_DESC + 7'd5, 16'hFFFF);
    regCheck(A_DESC + 7'd5, 16'h7F0F, "R2 descriptor mask");
    regWrite(A_PAR + 7'd5, 16'hFFFF);
    regCheck(A_PAR + 7'd5, 16'hFFFF, "R2 address reg full width");
    // R3 status register bits
    regWrite(A_CTL, 16'hFFFF);
    regCheck(A_CTL, 16'hE26F, "R3 writable bits");
    regWrite(A_CTL, 16'h0C00);
    regCheck(A_CTL, 16'h0000, "R3 bits 11:10 read zero");
    // R4 disabled: non-resident page 0 passes
    access(16'h0010, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, "R4 disabled access");
    regCheck(A_CTL, 16'h0000, "R4 status untouched");
    regCheck(A_FADR, 16'h0000, "R4 fetch addr untouched");
    // descriptors (plf<<8 | ed<<3 | acf), index mode*8+page
    regWrite(A_DESC + 7'd0, 16'h7F06);
    regWrite(A_DESC + 7'd1, 16'h7F00);
    regWrite(A_DESC + 7'd2, 16'h7F02);
    regWrite(A_DESC + 7'd3, 16'h7F01);
    regWrite(A_DESC + 7'd4, 16'h0A0E);
    regWrite(A_DESC + 7'd5, 16'h7F04);
    regWrite(A_DESC + 7'd7, 16'h7F05);
    regWrite(A_CTL, 16'h0201);
    access(16'h0100, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R6 rw page read passes");
    access(16'h0040, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, "R12 fetch no abort");
    regCheck(A_FADR, 16'h0040, "R12 fetch addr follows");
    // R5 non-resident
    access(16'h2000, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, "R5 non-resident abort");
    regCheck(A_CTL, 16'h8203, "R5 status word");
    regCheck(A_FADR, 16'h2000, "R12 aborting fetch addr");
    // R11 freeze
    access(16'h4010, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, "R11 abort while frozen");
    access(16'h0080, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, "R11 fetch while frozen");
    regCheck(A_CTL, 16'h8203, "R11 status frozen");
    regCheck(A_FADR, 16'h2000, "R11 fetch addr frozen");
    regWrite(A_CTL, 16'h0201);
    regCheck(A_CTL, 16'h0201, "R11 released by write");
    // R6 read-only
    access(16'h4010, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R6 read-only read passes");
    access(16'h4010, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, "R6 read-only write aborts");
    regCheck(A_CTL, 16'h2205, "R6 status word");
    regWrite(A_CTL, 16'h0201);
    access(16'h6000, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, "R6 code1 write aborts");
    regCheck(A_CTL, 16'h2207, "R6 code1 status word");
    regWrite(A_CTL, 16'h0201);
    // R7 upward length
    regWrite(A_DESC + 7'd1, 16'h0306);
    access(16'h20C0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R7 last legal block");
    access(16'h2100, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R7 block past limit");
    regCheck(A_CTL, 16'h4203, "R7 status word");
    regWrite(A_CTL, 16'h0201);
    // R8 downward length
    access(16'h8280, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R8 block at limit");
    access(16'h8240, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, "R8 block below limit");
    regCheck(A_CTL, 16'h4209, "R8 status word");
    regWrite(A_CTL, 16'h0201);
    // R9 / R10 bad mode
    access(16'hC080, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, "R9 mode 2 abort");
    regCheck(A_CTL, 16'hC24D, "R9 status word");
    regCheck(A_FADR, 16'hC080, "R12 mode 2 fetch addr");
    regWrite(A_CTL, 16'h0201);
    access(16'hA000, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, "R10 user mode abort");
    regCheck(A_CTL, 16'h826B, "R10 mode and page captured");
    regWrite(A_CTL, 16'h0201);
    // R13 traps
    access(16'h6000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R13 code1 read trap");
    access(16'hA000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R13 code4 read trap");
    access(16'hE000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R13 code5 read no trap");
    access(16'hE000, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, "R13 code5 write trap");
    access(16'h0100, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R13 code6 no trap");
    regCheck(A_CTL, 16'h0201, "R13 traps leave status");
    regWrite(A_CTL, 16'h0001);
    access(16'hA000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R13 trap disabled");
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule